// File: doc/BRIEF.md
# Threshold Trigger Decision Unit

This block forms a single accept/reject decision for every bunch crossing from a set of 32-bit words delivered in parallel by upstream processors. For each crossing it pulls 12-bit value fields out of selected words, combines them into a set of derived quantities, tests each quantity against a programmable threshold, and groups those test results into trigger channels. A channel fires when every test it has selected is true. Any firing channel makes the global decision true. One test result may be shared by any number of channels.

Every mapping in the chain can be reprogrammed at run time through a simple write port. The mappings are which word and field feed each quantity, which operator combines them, which quantity and comparison each test uses, its threshold, and which tests each channel requires. Writes land in shadow registers. They become live only at an orbit boundary, so no crossing is ever judged by a mixture of old and new settings. The pipeline accepts one crossing per clock and delivers its result a fixed three cycles later.

Top module: `trig_decision_unit`

## Requirements
- R1: While reset is asserted and right after it, `dec_valid`, `decision` and `chan_fire` are all 0, and every channel is disabled until a configuration has been committed.
- R2: Each operand of a derived quantity selects an input word by a 5-bit index and one of two 12-bit fields: slice 0 is bits [11:0] and slice 1 is bits [23:12]. A word index of `N_WORDS` or more yields the value 0.
- R3: A derived quantity is 13 bits wide and is computed with op code 0 as operand A unchanged, code 1 as A+B with no wrap, and code 2 as A−B clamped at 0. Code 3 behaves like code 0. The data register layout is: A word [4:0], A slice [5], B word [12:8], B slice [13], op [17:16].
- R4: A condition compares one derived quantity (source index in bits [3:0]; an index of `N_DATA` or more reads 0) with a 13-bit threshold (bits [24:12]) using the code in bits [5:4]. Code 0 means greater than, 1 means less than, 2 means equal, and 3 means never true.
- R5: A channel fires when its condition mask, an `N_COND`-bit register, is nonzero and every condition selected by the mask is true. A mask of 0 never fires.
- R6: `decision` is 1 exactly when at least one bit of `chan_fire` is 1.
- R7: The result for the crossing presented in cycle k appears on the outputs after the third rising edge that follows, and `dec_valid` repeats `xing_valid` with that delay.
- R8: Register writes go to shadow storage and have no effect on results until a crossing is presented with `orbit_end` high. That crossing is still judged with the old settings, and every later crossing uses the shadow contents as they stood before that edge.
- R9: A crossing presented with `xing_valid` low produces `dec_valid`, `decision` and all of `chan_fire` equal to 0.
- R10: The write address bits [6:5] select the register group (0 data, 1 condition, 2 channel) and bits [4:0] select the entry. Writes to group 3 or to an entry beyond the configured count change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock, one crossing per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xing_valid | input | 1 | Current crossing carries data |
| xing_words | input | N_WORDS*32 | Input words, word k in bits [32k+31:32k] |
| orbit_end | input | 1 | Current crossing is the last of an orbit; commits shadow configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Result on the outputs belongs to a valid crossing |
| chan_fire | output | N_CHAN | Per-channel fire flags |
| decision | output | 1 | Global decision |

## Verification
On every cycle the assertions check several properties. The decision must agree with the channel flags. An invalid result must be silent. The valid flag must trail the input valid by exactly three cycles. The live data and mask settings may only move in the cycles an orbit boundary allows. A channel with an empty mask must never fire. The field extraction, saturating subtraction, widened sum, each comparison code, out-of-range selectors and the deferred commit can only be shown by the bench's scenarios. The bench compares every output on every cycle against its own behavioural model and also checks hand-computed directed crossings.

// File: rtl/tdu_pkg.sv
package tdu_pkg;

  localparam int WORD_W = 32;
  localparam int VAL_W  = 12;
  localparam int SUM_W  = VAL_W + 1;
  localparam int WSEL_W = 5;
  localparam int DSEL_W = 4;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_RSV  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CMP_GT  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_EQ  = 2'd2,
    CMP_OFF = 2'd3
  } cmp_e;

  typedef enum logic [1:0] {
    GRP_DATA = 2'd0,
    GRP_COND = 2'd1,
    GRP_CHAN = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  typedef struct packed {
    op_e               op;
    logic              slice_b;
    logic [WSEL_W-1:0] word_b;
    logic              slice_a;
    logic [WSEL_W-1:0] word_a;
  } data_cfg_t;

  typedef struct packed {
    logic [SUM_W-1:0]  thr;
    cmp_e              cmp;
    logic [DSEL_W-1:0] src;
  } cond_cfg_t;

  function automatic logic [VAL_W-1:0] pick_field(input logic [WORD_W-1:0] w, input logic hi);
    return hi ? w[2*VAL_W-1:VAL_W] : w[VAL_W-1:0];
  endfunction

  function automatic logic [SUM_W-1:0] combine(input logic [VAL_W-1:0] a,
                                               input logic [VAL_W-1:0] b,
                                               input op_e op);
    logic [SUM_W-1:0] r;
    case (op)
      OP_ADD:  r = {1'b0, a} + {1'b0, b};
      OP_SUB:  r = (a > b) ? {1'b0, a - b} : '0;
      default: r = {1'b0, a};
    endcase
    return r;
  endfunction

  function automatic logic compare(input logic [SUM_W-1:0] d,
                                   input logic [SUM_W-1:0] thr,
                                   input cmp_e c);
    logic r;
    case (c)
      CMP_GT:  r = (d > thr);
      CMP_LT:  r = (d < thr);
      CMP_EQ:  r = (d == thr);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic data_cfg_t unpack_data(input logic [WORD_W-1:0] w);
    data_cfg_t c;
    c.word_a  = w[4:0];
    c.slice_a = w[5];
    c.word_b  = w[12:8];
    c.slice_b = w[13];
    c.op      = op_e'(w[17:16]);
    return c;
  endfunction

  function automatic cond_cfg_t unpack_cond(input logic [WORD_W-1:0] w);
    cond_cfg_t c;
    c.src = w[3:0];
    c.cmp = cmp_e'(w[5:4]);
    c.thr = w[24:12];
    return c;
  endfunction

endpackage

// File: rtl/tdu_data_stage.sv
module tdu_data_stage
  import tdu_pkg::*;
#(
  parameter int N_WORDS = 24,
  parameter int N_DATA  = 11
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld,
  input  data_cfg_t [N_DATA-1:0]          sh_cfg,
  input  logic                            in_valid,
  input  logic [N_WORDS*WORD_W-1:0]       in_words,
  output logic                            out_valid,
  output logic [N_DATA-1:0][SUM_W-1:0]    out_data,
  output data_cfg_t [N_DATA-1:0]          act_cfg
);

  logic [WORD_W-1:0]            words [N_WORDS];
  data_cfg_t [N_DATA-1:0]       act_q;
  logic [N_DATA-1:0][SUM_W-1:0] res;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    assign words[k] = in_words[k*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < N_DATA; i++) begin : g_item
    logic [VAL_W-1:0] fa;
    logic [VAL_W-1:0] fb;
    assign fa = (int'(act_q[i].word_a) < N_WORDS) ?
                pick_field(words[act_q[i].word_a], act_q[i].slice_a) : '0;
    assign fb = (int'(act_q[i].word_b) < N_WORDS) ?
                pick_field(words[act_q[i].word_b], act_q[i].slice_b) : '0;
    assign res[i] = combine(fa, fb, act_q[i].op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (ld) act_q <= sh_cfg;
      out_valid <= in_valid;
      out_data  <= res;
    end
  end

  assign act_cfg = act_q;

endmodule

// File: rtl/tdu_cond_stage.sv
module tdu_cond_stage
  import tdu_pkg::*;
#(
  parameter int N_DATA = 11,
  parameter int N_COND = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_snap,
  input  logic                          ld_live,
  input  cond_cfg_t [N_COND-1:0]        sh_cfg,
  input  logic                          in_valid,
  input  logic [N_DATA-1:0][SUM_W-1:0]  in_data,
  output logic                          out_valid,
  output logic [N_COND-1:0]             out_cond
);

  cond_cfg_t [N_COND-1:0] pend_q;
  cond_cfg_t [N_COND-1:0] act_q;
  logic [N_COND-1:0]      hit;

  for (genvar j = 0; j < N_COND; j++) begin : g_cond
    logic [SUM_W-1:0] d;
    assign d = (int'(act_q[j].src) < N_DATA) ? in_data[act_q[j].src] : '0;
    assign hit[j] = compare(d, act_q[j].thr, act_q[j].cmp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      act_q     <= '0;
      out_valid <= 1'b0;
      out_cond  <= '0;
    end else begin
      if (ld_snap) pend_q <= sh_cfg;
      if (ld_live) act_q  <= pend_q;
      out_valid <= in_valid;
      out_cond  <= hit;
    end
  end

endmodule

// File: rtl/tdu_chan_stage.sv
module tdu_chan_stage #(
  parameter int N_COND = 18,
  parameter int N_CHAN = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_snap,
  input  logic                           ld_mid,
  input  logic                           ld_live,
  input  logic [N_CHAN-1:0][N_COND-1:0]  sh_mask,
  input  logic                           in_valid,
  input  logic [N_COND-1:0]              in_cond,
  output logic                           out_valid,
  output logic [N_CHAN-1:0]              out_fire,
  output logic                           out_decision,
  output logic [N_CHAN-1:0][N_COND-1:0]  act_mask
);

  logic [N_CHAN-1:0][N_COND-1:0] pend1_q;
  logic [N_CHAN-1:0][N_COND-1:0] pend2_q;
  logic [N_CHAN-1:0][N_COND-1:0] act_q;
  logic [N_CHAN-1:0]             hit;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign hit[c] = (|act_q[c]) && ((in_cond & act_q[c]) == act_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend1_q      <= '0;
      pend2_q      <= '0;
      act_q        <= '0;
      out_valid    <= 1'b0;
      out_fire     <= '0;
      out_decision <= 1'b0;
    end else begin
      if (ld_snap) pend1_q <= sh_mask;
      if (ld_mid)  pend2_q <= pend1_q;
      if (ld_live) act_q   <= pend2_q;
      out_valid    <= in_valid;
      out_fire     <= in_valid ? hit : '0;
      out_decision <= in_valid && (|hit);
    end
  end

  assign act_mask = act_q;

endmodule

// File: rtl/trig_decision_unit.sv
module trig_decision_unit
  import tdu_pkg::*;
#(
  parameter int N_WORDS = 24,
  parameter int N_DATA  = 11,
  parameter int N_COND  = 18,
  parameter int N_CHAN  = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xing_valid,
  input  logic [N_WORDS*32-1:0]     xing_words,
  input  logic                      orbit_end,
  input  logic                      cfg_we,
  input  logic [6:0]                cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic                      dec_valid,
  output logic [N_CHAN-1:0]         chan_fire,
  output logic                      decision
);

  data_cfg_t [N_DATA-1:0]        sh_data;
  cond_cfg_t [N_COND-1:0]        sh_cond;
  logic [N_CHAN-1:0][N_COND-1:0] sh_mask;

  grp_e             wr_grp;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_wbits;

  assign wr_grp       = grp_e'(cfg_addr[ADDR_W-1:IDX_W]);
  assign wr_idx       = cfg_addr[IDX_W-1:0];
  assign unused_wbits = ^cfg_wdata[31:25];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data <= '0;
      sh_cond <= '0;
      sh_mask <= '0;
    end else if (cfg_we) begin
      case (wr_grp)
        GRP_DATA: if (int'(wr_idx) < N_DATA) sh_data[wr_idx] <= unpack_data(cfg_wdata);
        GRP_COND: if (int'(wr_idx) < N_COND) sh_cond[wr_idx] <= unpack_cond(cfg_wdata);
        GRP_CHAN: if (int'(wr_idx) < N_CHAN) sh_mask[wr_idx] <= cfg_wdata[N_COND-1:0];
        default: ;
      endcase
    end
  end

  // commit strobes staggered so each stage switches on the same crossing
  logic ld_s1, ld_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_s1 <= 1'b0;
      ld_s2 <= 1'b0;
    end else begin
      ld_s1 <= orbit_end;
      ld_s2 <= ld_s1;
    end
  end

  logic                           v1, v2;
  logic [N_DATA-1:0][SUM_W-1:0]   data_q;
  logic [N_COND-1:0]              cond_q;
  data_cfg_t [N_DATA-1:0]         data_act_w;
  logic [N_CHAN-1:0][N_COND-1:0]  mask_act_w;

  tdu_data_stage #(.N_WORDS(N_WORDS), .N_DATA(N_DATA)) u_data (
    .clk(clk), .rst_n(rst_n), .ld(orbit_end), .sh_cfg(sh_data),
    .in_valid(xing_valid), .in_words(xing_words),
    .out_valid(v1), .out_data(data_q), .act_cfg(data_act_w)
  );

  tdu_cond_stage #(.N_DATA(N_DATA), .N_COND(N_COND)) u_cond (
    .clk(clk), .rst_n(rst_n), .ld_snap(orbit_end), .ld_live(ld_s1), .sh_cfg(sh_cond),
    .in_valid(v1), .in_data(data_q),
    .out_valid(v2), .out_cond(cond_q)
  );

  tdu_chan_stage #(.N_COND(N_COND), .N_CHAN(N_CHAN)) u_chan (
    .clk(clk), .rst_n(rst_n), .ld_snap(orbit_end), .ld_mid(ld_s1), .ld_live(ld_s2),
    .sh_mask(sh_mask), .in_valid(v2), .in_cond(cond_q),
    .out_valid(dec_valid), .out_fire(chan_fire), .out_decision(decision),
    .act_mask(mask_act_w)
  );

endmodule

// File: rtl/tdu_checker.sv
module tdu_checker
  import tdu_pkg::*;
#(
  parameter int N_DATA = 11,
  parameter int N_COND = 18,
  parameter int N_CHAN = 14
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   xing_valid,
  input logic                                   orbit_end,
  input logic                                   dec_valid,
  input logic                                   decision,
  input logic [N_CHAN-1:0]                      chan_fire,
  input logic [N_DATA*$bits(data_cfg_t)-1:0]    act_data,
  input logic [N_CHAN-1:0][N_COND-1:0]          act_mask
);

  logic [2:0] warm;
  logic       warm_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm <= '0;
    else if (warm != 3'd7)    warm <= warm + 3'd1;
  end
  assign warm_ok = (warm >= 3'd4);

  AST_DECISION_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
    decision == (|chan_fire)); // R6

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (chan_fire == '0 && !decision)); // R9

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    warm_ok |-> (dec_valid == $past(xing_valid, 3))); // R7

  AST_DATA_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_ok && !$past(orbit_end)) |-> $stable(act_data)); // R8

  AST_MASK_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_ok && !$past(orbit_end, 3)) |-> $stable(act_mask)); // R8

  for (genvar c = 0; c < N_CHAN; c++) begin : g_empty
    AST_EMPTY_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_ok && chan_fire[c]) |-> ($past(act_mask[c]) != '0)); // R5
  end

endmodule

bind trig_decision_unit tdu_checker #(
  .N_DATA(N_DATA), .N_COND(N_COND), .N_CHAN(N_CHAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .orbit_end(orbit_end),
  .dec_valid(dec_valid), .decision(decision), .chan_fire(chan_fire),
  .act_data(data_act_w), .act_mask(mask_act_w)
);

// File: tb/sim_trig_decision_unit.sv
module sim_trig_decision_unit;

  localparam int NW = 24;
  localparam int ND = 11;
  localparam int NC = 18;
  localparam int NH = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            xing_valid = 1'b0;
  logic [NW*32-1:0] xing_words = '0;
  logic            orbit_end = 1'b0;
  logic            cfg_we = 1'b0;
  logic [6:0]      cfg_addr = '0;
  logic [31:0]     cfg_wdata = '0;
  logic            dec_valid;
  logic [NH-1:0]   chan_fire;
  logic            decision;

  always #5 clk = ~clk;

  trig_decision_unit u0 (
    .clk(clk), .rst_n(rst_n), .xing_valid(xing_valid), .xing_words(xing_words),
    .orbit_end(orbit_end), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dec_valid(dec_valid), .chan_fire(chan_fire), .decision(decision)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state: register images by address
  bit [31:0] sh  [128];
  bit [31:0] act [128];
  bit [31:0] w   [NW];

  typedef struct { bit v; bit [NH-1:0] f; bit d; } exp_t;
  exp_t q[$];

  // next inputs
  bit        n_v, n_orb, n_we;
  bit [6:0]  n_addr;
  bit [31:0] n_data;

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
    end
  endtask

  function automatic int fld(int idx, bit hi);
    if (idx >= NW) return 0;
    return hi ? int'((w[idx] >> 12) & 32'hFFF) : int'(w[idx] & 32'hFFF);
  endfunction

  function automatic int dval(int i);
    int a, b, op;
    a  = fld(int'(act[i] & 31), act[i][5]);
    b  = fld(int'((act[i] >> 8) & 31), act[i][13]);
    op = int'((act[i] >> 16) & 3);
    if (op == 1) return a + b;
    if (op == 2) return (a > b) ? a - b : 0;
    return a;
  endfunction

  function automatic bit cval(int j);
    int src, cmp, thr, d;
    src = int'(act[32+j] & 15);
    cmp = int'((act[32+j] >> 4) & 3);
    thr = int'((act[32+j] >> 12) & 13'h1FFF);
    d   = (src < ND) ? dval(src) : 0;
    case (cmp)
      0: return d > thr;
      1: return d < thr;
      2: return d == thr;
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(bit v);
    exp_t e;
    bit [NC-1:0] cs;
    e.v = v; e.f = '0; e.d = 0;
    for (int j = 0; j < NC; j++) cs[j] = cval(j);
    for (int c = 0; c < NH; c++) begin
      bit [NC-1:0] m;
      m = act[64+c][NC-1:0];
      if (v && m != 0 && (cs & m) == m) e.f[c] = 1;
    end
    e.d = |e.f;
    return e;
  endfunction

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (done) return;
    e = q.pop_front();
    chk("R7 dec_valid", int'(dec_valid), int'(e.v));
    chk("R5 chan_fire", int'(chan_fire), int'(e.f));
    chk("R6 decision", int'(decision), int'(e.d));
    xing_valid = n_v;
    orbit_end  = n_orb;
    cfg_we     = n_we;
    cfg_addr   = n_addr;
    cfg_wdata  = n_data;
    for (int k = 0; k < NW; k++) xing_words[k*32 +: 32] = w[k];
    q.push_back(model(n_v));
    if (n_orb) for (int a = 0; a < 128; a++) act[a] = sh[a];
    if (n_we) sh[n_addr] = n_data;
    n_v = 0; n_orb = 0; n_we = 0;
  endtask

  task automatic wr(input int addr, input bit [31:0] data);
    n_we = 1; n_addr = addr[6:0]; n_data = data;
    step();
  endtask

  function automatic bit [31:0] enc_d(int wa, bit sa, int wb, bit sb, int op);
    return 32'(wa) | (32'(sa) << 5) | (32'(wb) << 8) | (32'(sb) << 13) | (32'(op) << 16);
  endfunction

  function automatic bit [31:0] enc_c(int src, int cmp, int thr);
    return 32'(src) | (32'(cmp) << 4) | (32'(thr) << 12);
  endfunction

  task automatic pattern(bit b);
    for (int k = 0; k < NW; k++) w[k] = 0;
    w[0] = b ? 32'h0010_0010 : 32'h0010_0050;
    w[1] = 32'h0000_0030;
    w[2] = b ? 32'h0 : 32'h0000_0FFF;
  endtask

  // present one crossing, wait out the pipeline, sample after the third edge
  logic [NH-1:0] pk_f;
  logic          pk_d, pk_v;
  task automatic probe(input bit v, input bit orb);
    n_v = v; n_orb = orb;
    step(); step(); step();
    @(posedge clk); #1;
    pk_f = chan_fire; pk_d = decision; pk_v = dec_valid;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t z;
    for (int a = 0; a < 128; a++) begin sh[a] = 0; act[a] = 0; end
    for (int k = 0; k < NW; k++) w[k] = 0;
    repeat (5) @(negedge clk);
    chk("R1 reset dec_valid", int'(dec_valid), 0);
    chk("R1 reset chan_fire", int'(chan_fire), 0);
    chk("R1 reset decision", int'(decision), 0);
    rst_n = 1;
    z.v = 0; z.f = '0; z.d = 0;
    repeat (3) q.push_back(z);

    // directed configuration (R2 R3 R4 R10 encodings)
    wr(0,  enc_d(0, 0, 0, 0, 0));
    wr(1,  enc_d(0, 0, 1, 0, 1));
    wr(2,  enc_d(1, 0, 0, 0, 2));
    wr(3,  enc_d(0, 1, 0, 0, 0));
    wr(4,  enc_d(30, 0, 0, 0, 0));
    wr(5,  enc_d(2, 0, 2, 0, 1));
    wr(32, enc_c(0, 0, 79));
    wr(33, enc_c(0, 0, 80));
    wr(34, enc_c(1, 2, 128));
    wr(35, enc_c(2, 2, 0));
    wr(36, enc_c(3, 1, 257));
    wr(37, enc_c(4, 2, 0));
    wr(38, enc_c(5, 0, 8189));
    wr(39, enc_c(0, 3, 0));
    wr(64, 32'h5);
    wr(65, 32'h3);
    wr(66, 32'h28);
    wr(67, 32'h50);
    wr(68, 32'h80);
    wr(96, 32'hFFFF_FFFF);   // group 3: no effect
    wr(78, 32'h1);           // channel entry 14 does not exist

    pattern(0);
    probe(1, 0);
    chk("R8 nothing live before commit", int'(pk_f), 0);
    chk("R1 channels disabled after reset", int'(pk_d), 0);

    probe(0, 1);
    pattern(0);
    probe(1, 0);
    chk("R7 valid after three edges", int'(pk_v), 1);
    chk("R4 gt true + R2 low slice", int'(pk_f[0]), 1);
    chk("R4 gt strict", int'(pk_f[1]), 0);
    chk("R3 sub clamps, R2 far index reads 0", int'(pk_f[2]), 1);
    chk("R3 add widens, R2 high slice, R4 lt", int'(pk_f[3]), 1);
    chk("R4 code 3 never true", int'(pk_f[4]), 0);
    chk("R5 zero mask silent, R10 ignored writes", int'(pk_f), 'h000D);
    chk("R6 decision high", int'(pk_d), 1);

    pattern(1);
    probe(1, 0);
    chk("R5 all channels miss", int'(pk_f), 0);
    chk("R6 decision low", int'(pk_d), 0);

    pattern(0);
    probe(0, 0);
    chk("R9 invalid chan_fire", int'(pk_f), 0);
    chk("R9 invalid decision", int'(pk_d), 0);
    chk("R9 invalid dec_valid", int'(pk_v), 0);

    wr(69, 32'h1);
    probe(1, 0);
    chk("R8 shadow write not live", int'(pk_f), 'h000D);
    probe(1, 1);
    chk("R8 orbit crossing uses old", int'(pk_f), 'h000D);
    probe(1, 0);
    chk("R8 committed after orbit", int'(pk_f), 'h002D);

    // randomized run against the model
    for (int cyc = 0; cyc < 3000; cyc++) begin
      for (int k = 0; k < NW; k++)
        w[k] = {$urandom() % 256, 12'($urandom() % 64), 12'($urandom() % 64)};
      n_v   = ($urandom() % 10) != 0;
      n_orb = (cyc % 16) == 15;
      if (($urandom() % 4) == 0) begin
        int g;
        g = $urandom() % 3;
        n_we = 1;
        if (g == 0) begin
          n_addr = 7'($urandom() % ND);
          n_data = enc_d($urandom() % 32, $urandom() % 2, $urandom() % 32, $urandom() % 2, $urandom() % 4);
        end else if (g == 1) begin
          n_addr = 7'(32 + $urandom() % NC);
          n_data = enc_c($urandom() % 16, $urandom() % 4, $urandom() % 130);
        end else begin
          n_addr = 7'(64 + $urandom() % NH);
          n_data = ($urandom() & $urandom() & $urandom()) & 32'h3FFFF;
        end
      end
      step();
    end
    repeat (4) step();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule